// File: doc/BRIEF.md
# NAND Page Hamming ECC Engine

This block computes a single-error-correct, double-error-detect parity code over a NAND flash page while the page bytes stream past it, one byte per clock at most. The page is cut into 512-byte sectors. During a write pass the engine emits one 24-bit check code per sector. During a read pass it takes in the check code that was stored for each sector and compares it with the code it recomputed. It then sorts the sector into one of four outcomes: clean, a correctable data error, a corrupted stored code, or multiple errors. For a correctable error it reports the byte offset and the bit index, so that software can repair the byte.

The code holds two 12-bit halves. The low half P[11:0] has one bit per address line of the 12-bit bit address {byte_offset[8:0], bit_index[2:0]}. The high half NP[23:12] holds the complementary bits for the same lines. Each set data bit toggles P[k] when bit k of its address is one, and it toggles NP[k] when that address bit is zero. A single flipped data bit therefore changes exactly one member of every P/NP pair. The P half of the syndrome is then the error address.

Control is a three-state machine. ST_IDLE ignores all traffic until a command starts. On cmd_start the machine enters ST_DATA, where it accepts bytes and counts the offset within the sector. On the 512th byte of a write sector it emits the code and stays in ST_DATA for the next sector. After the last sector it returns to ST_IDLE. On the 512th byte of a read sector it moves to ST_CODE_WAIT and holds there until code_valid. It then classifies the sector and returns to ST_DATA, or to ST_IDLE after the last sector. From any state, sw_reset leads to ST_IDLE and cmd_start leads to ST_DATA.

Top module: `nand_ecc_engine`

## Requirements
- R1: In write mode, code_out carries the 24-bit code for the sector one cycle after the sector's 512th accepted byte, with code_out_valid and sector_done high for that one cycle. The code has P[k] in bit k and NP[k] in bit 12+k. P[k] is the XOR of all data bits whose address {offset,bit} has bit k set, and NP[k] is the XOR of those whose address has bit k clear.
- R2: page_sel, sampled at cmd_start, selects 1 sector (0), 4 sectors (1) or 8 sectors (2 or 3). page_done pulses together with sector_done for the final sector, and done_sector gives the index of the sector that just finished.
- R3: A read sector whose recomputed code XOR stored code is zero sets none of its three flags.
- R4: A read sector whose syndrome halves XOR to all ones sets rec_err[sector]. In that case err_byte equals syndrome[11:3] and err_bit equals syndrome[2:0]. Any other read result sets err_byte and err_bit to zero.
- R5: A syndrome with exactly one set bit out of 24 sets code_err[sector].
- R6: Any other nonzero syndrome sets multi_err[sector].
- R7: cmd_start clears all flags, code_out, err_byte, err_bit, done_sector and the parity accumulator. The new command starts at sector 0, offset 0.
- R8: sw_reset clears the same state as R7 and returns to ST_IDLE. It takes precedence over a cmd_start in the same cycle.
- R9: byte_valid is ignored in ST_IDLE, in ST_CODE_WAIT and in the cmd_start cycle. code_valid is ignored outside ST_CODE_WAIT. At most one flag is set per sector, and the flags stay set until cleared.
- R10: A read sector's result, sector_done and flags appear one cycle after code_valid is accepted. ST_CODE_WAIT is only reached in read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_reset | input | 1 | Synchronous clear to idle |
| cmd_start | input | 1 | Start of a read or write command |
| cmd_is_read | input | 1 | 1 = read pass, 0 = write pass (sampled at cmd_start) |
| page_sel | input | 2 | Page size select (sampled at cmd_start) |
| byte_valid | input | 1 | byte_data holds a page byte |
| byte_data | input | 8 | Page byte |
| code_valid | input | 1 | code_in holds the stored code of the current sector |
| code_in | input | 24 | Stored check code |
| code_out | output | 24 | Computed code of the last written sector |
| code_out_valid | output | 1 | One-cycle pulse with a new code_out |
| sector_done | output | 1 | One-cycle pulse when a sector completes |
| done_sector | output | 3 | Index of the sector that completed |
| page_done | output | 1 | One-cycle pulse when the final sector completes |
| rec_err | output | 8 | Correctable data error flag per sector |
| code_err | output | 8 | Stored-code corruption flag per sector |
| multi_err | output | 8 | Uncorrectable error flag per sector |
| err_byte | output | 9 | Faulty byte offset of the last read sector |
| err_bit | output | 3 | Faulty bit index of the last read sector |

## Verification
Some properties are checked on every cycle:
- The three flag vectors never mark the same sector twice.
- sector_done only follows an accepted last byte or an accepted code.
- sw_reset always clears the flags, and cmd_start zeroes the accumulator.
- page_done only occurs with the machine back in ST_IDLE.
- The machine never waits for a code during a write.
- A sector classed as a data error carries a twelve-bit syndrome weight.

Other behaviour only the scenarios can show:
- The actual code values.
- The located byte and bit at offsets 0 and 511.
- The sorting of a mixed four-sector page into each outcome.
- That bytes sent while idle or waiting leave the results unchanged.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;

    // Address lines that select a bit inside one byte
    localparam int BIT_AW = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_CODE_WAIT
    } ecc_state_t;

    typedef enum logic [1:0] {
        OUT_CLEAN,
        OUT_DATA_ERR,
        OUT_CODE_ERR,
        OUT_MULTI
    } ecc_outcome_t;

endpackage

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
    import nand_ecc_pkg::*;
#(
    parameter  int BYTE_AW = 9,
    localparam int LINES   = BYTE_AW + BIT_AW,
    localparam int CW      = 2 * LINES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               en,
    input  logic [BYTE_AW-1:0] byte_addr,
    input  logic [7:0]         data,
    output logic [CW-1:0]      acc,
    output logic [CW-1:0]      acc_next
);

    logic [LINES-1:0] p_c;
    logic [LINES-1:0] np_c;
    logic             byte_par;

    assign byte_par = ^data;

    // Bit-index lines: split the byte by each index bit
    always_comb begin
        for (int j = 0; j < BIT_AW; j++) begin
            p_c[j]  = 1'b0;
            np_c[j] = 1'b0;
            for (int b = 0; b < 8; b++) begin
                if (((b >> j) & 1) == 1) p_c[j]  = p_c[j]  ^ data[b];
                else                     np_c[j] = np_c[j] ^ data[b];
            end
        end
    end

    // Byte-offset lines: whole-byte parity steered by each address bit
    for (genvar k = 0; k < BYTE_AW; k++) begin : g_byte_line
        assign p_c[BIT_AW+k]  =  byte_addr[k] & byte_par;
        assign np_c[BIT_AW+k] = ~byte_addr[k] & byte_par;
    end

    assign acc_next = en ? (acc ^ {np_c, p_c}) : acc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     acc <= '0;
        else if (clear) acc <= '0;
        else            acc <= acc_next;
    end

    assert_clear_zeroes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc == '0));

endmodule

// File: rtl/ecc_syndrome_classify.sv
module ecc_syndrome_classify
    import nand_ecc_pkg::*;
#(
    parameter  int LINES = 12,
    localparam int CW    = 2 * LINES
) (
    input  logic [CW-1:0]    computed,
    input  logic [CW-1:0]    stored,
    output ecc_outcome_t     outcome,
    output logic [LINES-1:0] location
);

    logic [CW-1:0] syn;

    assign syn      = computed ^ stored;
    assign location = syn[LINES-1:0];

    always_comb begin
        if (syn == '0)
            outcome = OUT_CLEAN;
        else if ((syn[LINES-1:0] ^ syn[CW-1:LINES]) == '1)
            outcome = OUT_DATA_ERR;
        else if ($countones(syn) == 1)
            outcome = OUT_CODE_ERR;
        else
            outcome = OUT_MULTI;
    end

    always_comb begin
        if (outcome == OUT_DATA_ERR)
            assert_data_err_weight_R4: assert ($countones(syn) == LINES);
    end

endmodule

// File: rtl/ecc_sector_ctrl.sv
module ecc_sector_ctrl
    import nand_ecc_pkg::*;
#(
    parameter  int SECTOR_BYTES = 512,
    parameter  int MAX_SECTORS  = 8,
    localparam int BYTE_AW      = $clog2(SECTOR_BYTES),
    localparam int SEC_W        = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sw_reset,
    input  logic               cmd_start,
    input  logic               cmd_is_read,
    input  logic [1:0]         page_sel,
    input  logic               byte_valid,
    input  logic               code_valid,
    output ecc_state_t         state,
    output logic               rd_mode,
    output logic [BYTE_AW-1:0] byte_addr,
    output logic [SEC_W-1:0]   sector_idx,
    output logic               acc_en,
    output logic               acc_clear,
    output logic               wr_end,
    output logic               rd_end,
    output logic               page_end
);

    localparam logic [BYTE_AW-1:0] LAST_BYTE = BYTE_AW'(SECTOR_BYTES - 1);
    localparam logic [SEC_W-1:0]   LAST_FULL = SEC_W'(MAX_SECTORS - 1);
    localparam logic [SEC_W-1:0]   LAST_MID  = SEC_W'(MAX_SECTORS / 2 - 1);

    ecc_state_t         state_nx;
    logic [SEC_W-1:0]   last_idx;
    logic               ctl_hold;
    logic               byte_take;
    logic               last_sector;

    assign ctl_hold    = sw_reset | cmd_start;
    assign last_sector = (sector_idx == last_idx);

    // Next state
    always_comb begin
        state_nx = state;
        if (sw_reset)
            state_nx = ST_IDLE;
        else if (cmd_start)
            state_nx = ST_DATA;
        else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_DATA: begin
                    if (byte_valid && byte_addr == LAST_BYTE) begin
                        if (rd_mode)          state_nx = ST_CODE_WAIT;
                        else if (last_sector) state_nx = ST_IDLE;
                    end
                end
                ST_CODE_WAIT: begin
                    if (code_valid)
                        state_nx = last_sector ? ST_IDLE : ST_DATA;
                end
            endcase
        end
    end

    // State register and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            rd_mode    <= 1'b0;
            byte_addr  <= '0;
            sector_idx <= '0;
            last_idx   <= '0;
        end else begin
            state <= state_nx;
            if (sw_reset) begin
                byte_addr  <= '0;
                sector_idx <= '0;
            end else if (cmd_start) begin
                rd_mode    <= cmd_is_read;
                byte_addr  <= '0;
                sector_idx <= '0;
                unique case (page_sel)
                    2'd0:    last_idx <= '0;
                    2'd1:    last_idx <= LAST_MID;
                    default: last_idx <= LAST_FULL;
                endcase
            end else begin
                if (byte_take)
                    byte_addr <= (byte_addr == LAST_BYTE) ? '0 : byte_addr + 1'b1;
                if ((wr_end || rd_end) && !last_sector)
                    sector_idx <= sector_idx + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        byte_take = !ctl_hold && (state == ST_DATA) && byte_valid;
        acc_en    = byte_take;
        wr_end    = byte_take && !rd_mode && (byte_addr == LAST_BYTE);
        rd_end    = !ctl_hold && (state == ST_CODE_WAIT) && code_valid;
        page_end  = (wr_end || rd_end) && last_sector;
        acc_clear = ctl_hold || wr_end || rd_end;
    end

    assert_wait_needs_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CODE_WAIT) |-> rd_mode);

endmodule

// File: rtl/nand_ecc_engine.sv
module nand_ecc_engine
    import nand_ecc_pkg::*;
#(
    parameter  int SECTOR_BYTES = 512,
    parameter  int MAX_SECTORS  = 8,
    localparam int BYTE_AW      = $clog2(SECTOR_BYTES),
    localparam int LINES        = BYTE_AW + BIT_AW,
    localparam int CODE_W       = 2 * LINES,
    localparam int SEC_W        = (MAX_SECTORS > 1) ? $clog2(MAX_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sw_reset,
    input  logic                   cmd_start,
    input  logic                   cmd_is_read,
    input  logic [1:0]             page_sel,
    input  logic                   byte_valid,
    input  logic [7:0]             byte_data,
    input  logic                   code_valid,
    input  logic [CODE_W-1:0]      code_in,
    output logic [CODE_W-1:0]      code_out,
    output logic                   code_out_valid,
    output logic                   sector_done,
    output logic [SEC_W-1:0]       done_sector,
    output logic                   page_done,
    output logic [MAX_SECTORS-1:0] rec_err,
    output logic [MAX_SECTORS-1:0] code_err,
    output logic [MAX_SECTORS-1:0] multi_err,
    output logic [BYTE_AW-1:0]     err_byte,
    output logic [BIT_AW-1:0]      err_bit
);

    ecc_state_t         state;
    logic               rd_mode;
    logic [BYTE_AW-1:0] byte_addr;
    logic [SEC_W-1:0]   sector_idx;
    logic               acc_en, acc_clear, wr_end, rd_end, page_end;
    logic [CODE_W-1:0]  acc, acc_next;
    ecc_outcome_t       outcome;
    logic [LINES-1:0]   location;

    ecc_sector_ctrl #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .MAX_SECTORS  (MAX_SECTORS)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .sw_reset    (sw_reset),
        .cmd_start   (cmd_start),
        .cmd_is_read (cmd_is_read),
        .page_sel    (page_sel),
        .byte_valid  (byte_valid),
        .code_valid  (code_valid),
        .state       (state),
        .rd_mode     (rd_mode),
        .byte_addr   (byte_addr),
        .sector_idx  (sector_idx),
        .acc_en      (acc_en),
        .acc_clear   (acc_clear),
        .wr_end      (wr_end),
        .rd_end      (rd_end),
        .page_end    (page_end)
    );

    ecc_parity_accum #(
        .BYTE_AW (BYTE_AW)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acc_clear),
        .en        (acc_en),
        .byte_addr (byte_addr),
        .data      (byte_data),
        .acc       (acc),
        .acc_next  (acc_next)
    );

    ecc_syndrome_classify #(
        .LINES (LINES)
    ) u_classify (
        .computed (acc),
        .stored   (code_in),
        .outcome  (outcome),
        .location (location)
    );

    // Result and status registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_out       <= '0;
            code_out_valid <= 1'b0;
            sector_done    <= 1'b0;
            done_sector    <= '0;
            page_done      <= 1'b0;
            rec_err        <= '0;
            code_err       <= '0;
            multi_err      <= '0;
            err_byte       <= '0;
            err_bit        <= '0;
        end else begin
            code_out_valid <= 1'b0;
            sector_done    <= 1'b0;
            page_done      <= 1'b0;
            if (sw_reset || cmd_start) begin
                code_out    <= '0;
                done_sector <= '0;
                rec_err     <= '0;
                code_err    <= '0;
                multi_err   <= '0;
                err_byte    <= '0;
                err_bit     <= '0;
            end else if (wr_end) begin
                code_out       <= acc_next;
                code_out_valid <= 1'b1;
                sector_done    <= 1'b1;
                done_sector    <= sector_idx;
                page_done      <= page_end;
            end else if (rd_end) begin
                sector_done <= 1'b1;
                done_sector <= sector_idx;
                page_done   <= page_end;
                err_byte    <= '0;
                err_bit     <= '0;
                unique case (outcome)
                    OUT_CLEAN:    ;
                    OUT_DATA_ERR: begin
                        rec_err[sector_idx] <= 1'b1;
                        err_byte            <= location[LINES-1:BIT_AW];
                        err_bit             <= location[BIT_AW-1:0];
                    end
                    OUT_CODE_ERR: code_err[sector_idx]  <= 1'b1;
                    OUT_MULTI:    multi_err[sector_idx] <= 1'b1;
                endcase
            end
        end
    end

    assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((rec_err & code_err) | (rec_err & multi_err) | (code_err & multi_err)) == '0);

    assert_result_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sector_done |-> $past(wr_end || rd_end));

    assert_sw_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sw_reset |=> (rec_err == '0 && code_err == '0 && multi_err == '0 && !sector_done));

    assert_code_only_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_out_valid |-> !rd_mode);

    assert_page_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        page_done |-> (state == ST_IDLE));

endmodule

// File: tb/tb_nand_ecc_engine.sv
module tb_nand_ecc_engine;

    localparam int CLK_PERIOD = 10;
    localparam int SB         = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_reset = 1'b0;
    logic        cmd_start = 1'b0;
    logic        cmd_is_read = 1'b0;
    logic [1:0]  page_sel = 2'd0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        code_valid = 1'b0;
    logic [23:0] code_in = 24'h0;
    logic [23:0] code_out;
    logic        code_out_valid;
    logic        sector_done;
    logic [2:0]  done_sector;
    logic        page_done;
    logic [7:0]  rec_err, code_err, multi_err;
    logic [8:0]  err_byte;
    logic [2:0]  err_bit;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_ecc_engine dut (
        .clk(clk), .rst_n(rst_n), .sw_reset(sw_reset), .cmd_start(cmd_start),
        .cmd_is_read(cmd_is_read), .page_sel(page_sel), .byte_valid(byte_valid),
        .byte_data(byte_data), .code_valid(code_valid), .code_in(code_in),
        .code_out(code_out), .code_out_valid(code_out_valid), .sector_done(sector_done),
        .done_sector(done_sector), .page_done(page_done), .rec_err(rec_err),
        .code_err(code_err), .multi_err(multi_err), .err_byte(err_byte), .err_bit(err_bit)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit cmp_en   = 1'b0;
    int sd_cnt   = 0;
    int pd_cnt   = 0;
    int pd_sector = 0;

    logic [7:0]  page_mem [0:4095];
    logic [23:0] stored [0:7];

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural code: P in [11:0], NP in [23:12], address = offset*8 + bit
    function automatic logic [23:0] code_of(input logic [7:0] arr [0:SB-1]);
        logic [11:0] p = '0;
        logic [11:0] np = '0;
        for (int i = 0; i < SB; i++)
            for (int b = 0; b < 8; b++)
                if (arr[i][b])
                    for (int k = 0; k < 12; k++)
                        if ((((i * 8 + b) >> k) & 1) == 1) p[k] = ~p[k];
                        else np[k] = ~np[k];
        return {np, p};
    endfunction

    function automatic logic [23:0] mem_code(input int base);
        logic [7:0] tmp [0:SB-1];
        for (int i = 0; i < SB; i++) tmp[i] = page_mem[base + i];
        return code_of(tmp);
    endfunction

    // Reference model state
    bit          m_act, m_rd, m_wt;
    int          m_cnt, m_sec, m_ns;
    logic [7:0]  m_buf [0:SB-1];
    logic [23:0] e_code;
    logic        e_cv, e_sd, e_pd;
    logic [2:0]  e_ds;
    logic [7:0]  e_rec, e_cerr, e_mul;
    logic [8:0]  e_eb;
    logic [2:0]  e_ebit;

    task automatic m_clear();
        e_code = '0; e_ds = '0; e_rec = '0; e_cerr = '0; e_mul = '0;
        e_eb = '0; e_ebit = '0; m_act = 1'b0; m_wt = 1'b0;
    endtask

    task automatic m_finish_sector();
        e_sd = 1'b1;
        e_ds = 3'(m_sec);
        if (m_sec == m_ns - 1) begin
            e_pd = 1'b1;
            m_act = 1'b0;
        end else begin
            m_sec++;
        end
    endtask

    always @(posedge clk) begin
        logic [23:0] syn;
        bit          found;
        e_cv = 1'b0; e_sd = 1'b0; e_pd = 1'b0;
        if (!rst_n) begin
            m_clear();
        end else if (sw_reset) begin
            m_clear();
        end else if (cmd_start) begin
            m_clear();
            m_act = 1'b1;
            m_rd  = cmd_is_read;
            m_ns  = (page_sel == 2'd0) ? 1 : (page_sel == 2'd1) ? 4 : 8;
            m_sec = 0;
            m_cnt = 0;
        end else if (m_act && !m_wt && byte_valid) begin
            m_buf[m_cnt] = byte_data;
            if (m_cnt == SB - 1) begin
                m_cnt = 0;
                if (!m_rd) begin
                    e_code = code_of(m_buf);
                    e_cv = 1'b1;
                    m_finish_sector();
                end else begin
                    m_wt = 1'b1;
                end
            end else begin
                m_cnt++;
            end
        end else if (m_act && m_wt && code_valid) begin
            m_wt = 1'b0;
            syn = code_of(m_buf) ^ code_in;
            found = 1'b0;
            e_eb = '0; e_ebit = '0;
            if (syn != '0) begin
                for (int a = 0; a < SB * 8; a++)
                    if (syn == {~12'(a), 12'(a)}) begin
                        found = 1'b1;
                        e_eb = 9'(a / 8);
                        e_ebit = 3'(a % 8);
                    end
                if (found)                     e_rec[m_sec]  = 1'b1;
                else if ($countones(syn) == 1) e_cerr[m_sec] = 1'b1;
                else                           e_mul[m_sec]  = 1'b1;
            end
            m_finish_sector();
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            check("R1", "code_out", 32'(code_out), 32'(e_code));
            check("R1", "code_out_valid", 32'(code_out_valid), 32'(e_cv));
            check("R10", "sector_done", 32'(sector_done), 32'(e_sd));
            check("R2", "done_sector", 32'(done_sector), 32'(e_ds));
            check("R2", "page_done", 32'(page_done), 32'(e_pd));
            check("R4", "rec_err", 32'(rec_err), 32'(e_rec));
            check("R5", "code_err", 32'(code_err), 32'(e_cerr));
            check("R6", "multi_err", 32'(multi_err), 32'(e_mul));
            check("R4", "err_byte", 32'(err_byte), 32'(e_eb));
            check("R4", "err_bit", 32'(err_bit), 32'(e_ebit));
            if (sector_done) sd_cnt++;
            if (page_done) begin
                pd_cnt++;
                pd_sector = int'(done_sector);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_fail++;
            $display("FAIL R10 watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic send_bytes(input int base, input int count);
        for (int i = 0; i < count; i++) begin
            byte_valid = 1'b1;
            byte_data  = page_mem[base + i];
            @(negedge clk);
            if (i % 97 == 50) begin
                byte_valid = 1'b0;
                @(negedge clk);
            end
        end
        byte_valid = 1'b0;
    endtask

    task automatic send_page(input bit rd, input logic [1:0] sel, input int junk);
        int ns = (sel == 2'd0) ? 1 : (sel == 2'd1) ? 4 : 8;
        @(negedge clk);
        cmd_start = 1'b1; cmd_is_read = rd; page_sel = sel;
        byte_valid = 1'b1; byte_data = 8'hA5;
        @(negedge clk);
        cmd_start = 1'b0; byte_valid = 1'b0;
        for (int s = 0; s < ns; s++) begin
            send_bytes(s * SB, SB);
            if (rd) begin
                for (int j = 0; j < junk; j++) begin
                    byte_valid = 1'b1; byte_data = 8'($urandom);
                    @(negedge clk);
                end
                byte_valid = 1'b0;
                code_valid = 1'b1; code_in = stored[s];
                @(negedge clk);
                code_valid = 1'b0;
            end
        end
        for (int j = 0; j < junk; j++) begin
            byte_valid = 1'b1; byte_data = 8'($urandom);
            code_valid = 1'b1; code_in = 24'($urandom);
            @(negedge clk);
        end
        byte_valid = 1'b0; code_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) page_mem[i] = 8'($urandom);
    endtask

    initial begin
        int sd_before;
        int pd_before;
        repeat (3) @(negedge clk);
        check("R8", "reset code_out", 32'(code_out), 32'h0);
        check("R8", "reset flags", 32'({rec_err, code_err, multi_err}), 32'h0);
        check("R8", "reset pulses", 32'({sector_done, page_done, code_out_valid}), 32'h0);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        @(negedge clk);

        // Single-sector write
        fill(SB);
        send_page(1'b0, 2'd0, 0);
        check("R1", "written code", 32'(code_out), 32'(mem_code(0)));

        // Clean read with ignored bytes during code wait and after the page
        stored[0] = mem_code(0);
        send_page(1'b1, 2'd0, 3);
        check("R3", "clean flags", 32'({rec_err, code_err, multi_err}), 32'h0);
        check("R9", "junk ignored, one sector done", 32'(done_sector), 32'h0);

        // Four-sector read: multi, code error, clean, data error
        fill(4 * SB);
        for (int s = 0; s < 4; s++) stored[s] = mem_code(s * SB);
        page_mem[10]  ^= 8'h01;
        page_mem[400] ^= 8'h40;
        stored[1]     ^= 24'h020000;
        page_mem[3 * SB + 300] ^= 8'h20;
        pd_before = pd_cnt;
        send_page(1'b1, 2'd1, 2);
        check("R4", "rec_err mixed", 32'(rec_err), 32'h08);
        check("R5", "code_err mixed", 32'(code_err), 32'h02);
        check("R6", "multi_err mixed", 32'(multi_err), 32'h01);
        check("R4", "err_byte 300", 32'(err_byte), 32'd300);
        check("R4", "err_bit 5", 32'(err_bit), 32'd5);
        check("R2", "page_done once", 32'(pd_cnt - pd_before), 32'd1);
        check("R2", "last sector index 3", 32'(pd_sector), 32'd3);

        // New command clears prior status
        @(negedge clk);
        cmd_start = 1'b1; cmd_is_read = 1'b0; page_sel = 2'd0;
        @(negedge clk);
        cmd_start = 1'b0;
        check("R7", "flags after cmd_start", 32'({rec_err, code_err, multi_err}), 32'h0);
        check("R7", "err_byte after cmd_start", 32'(err_byte), 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Corner offsets: last byte bit 7, first byte bit 0
        fill(SB);
        stored[0] = mem_code(0);
        page_mem[511] ^= 8'h80;
        send_page(1'b1, 2'd0, 0);
        check("R4", "err_byte 511", 32'(err_byte), 32'd511);
        check("R4", "err_bit 7", 32'(err_bit), 32'd7);
        page_mem[511] ^= 8'h80;
        page_mem[0]   ^= 8'h01;
        send_page(1'b1, 2'd0, 0);
        check("R4", "rec_err at offset 0", 32'(rec_err), 32'h01);
        check("R4", "err_byte 0", 32'(err_byte), 32'd0);

        // Software reset mid-write, then with cmd_start in the same cycle
        fill(4096);
        @(negedge clk);
        cmd_start = 1'b1; cmd_is_read = 1'b0; page_sel = 2'd2;
        @(negedge clk);
        cmd_start = 1'b0;
        send_bytes(0, 200);
        sw_reset = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0;
        check("R8", "flags after sw_reset", 32'({rec_err, code_err, multi_err}), 32'h0);
        check("R8", "code_out after sw_reset", 32'(code_out), 32'h0);
        sd_before = sd_cnt;
        sw_reset = 1'b1; cmd_start = 1'b1;
        @(negedge clk);
        sw_reset = 1'b0; cmd_start = 1'b0;
        send_bytes(0, 600);
        repeat (2) @(negedge clk);
        check("R8", "sw_reset wins over cmd_start", 32'(sd_cnt - sd_before), 32'd0);

        // Full eight-sector write with page_sel 3
        pd_before = pd_cnt;
        sd_before = sd_cnt;
        send_page(1'b0, 2'd3, 2);
        check("R2", "eight sectors done", 32'(sd_cnt - sd_before), 32'd8);
        check("R2", "page_done once, eight", 32'(pd_cnt - pd_before), 32'd1);
        check("R2", "last sector index 7", 32'(pd_sector), 32'd7);
        check("R1", "last sector code", 32'(code_out), 32'(mem_code(7 * SB)));

        cmp_en = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule